// File: doc/BRIEF.md
# Timeout-Framed Serial Position Reader

This block is the controller end of a simplex, clock-driven serial link that reads an absolute position word from a remote sensor. The sensor has no select line. It freezes its value when the clock first drops and then shifts the value out on the clock's rising edges. It releases the value only after the clock has stayed high for longer than its own timeout. When `start_i` is pulsed in idle, the reader produces one burst of WORD_W+1 clock periods at a rate set by `half_i` and collects the bits into a parallel word. It also checks the line for cabling faults. The check uses the level seen in idle, which must be high, and the level seen after the final rising edge, which must be low.

In compare mode the reader keeps the clock running. A second burst starts one half period after the first one ends, which is well inside the sensor's timeout, so the sensor repeats the same frozen word. The reader compares the two copies. The word, a one-cycle valid strobe and three fault flags are delivered together. The reader then holds the clock high for a guard time of TM_CYC cycles, during which new requests are refused. This guard lets the sensor time out and refresh its value before the next independent read.

Top module: `sync_link_reader`

## Requirements
- R1: After reset and whenever the reader is not busy, `sclk_o` is high, `busy_o` is low and `valid_o` is low.
- R2: A `start_i` pulse taken in idle starts a burst that begins with the clock going low. Every low phase and every high phase lasts `half_i` cycles (valid range 4 to 2^DIV_W-1; the value is latched at start). A single read has exactly WORD_W+1 rising edges.
- R3: `sdata_i` passes through a two-flop synchroniser and is sampled at the end of each high phase, which is the falling edge after the rising edge that presented the bit. The bit after rising edge 1 lands in `word_o[WORD_W-1]` (MSB first) and the bit after rising edge WORD_W lands in `word_o[0]`.
- R4: If the synchronised data line is low when the start request is accepted, `wire_break_o` is reported as 1 with that read.
- R5: If the data line is high at the end of the high phase after rising edge WORD_W+1, `short_o` is reported as 1. In compare mode this check applies to either burst.
- R6: In compare mode (`cmp_mode_i`=1 at start) the second burst's falling edge follows one half period after the first burst's last high phase, so a read has 2*(WORD_W+1) rising edges. `word_o` carries the first copy, and `mismatch_o` is 1 exactly when the two copies differ. In single mode `mismatch_o` is 0.
- R7: `valid_o` is high for exactly one cycle, with `word_o` and all flags valid in that cycle. It is raised even when a flag is set.
- R8: `busy_o` stays high with `sclk_o` high for exactly TM_CYC cycles, counting the cycle in which `valid_o` is high, and then drops.
- R9: A `start_i` pulse while `busy_o` is high is ignored: no clock edge follows it and no extra result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, taken only in idle |
| cmp_mode_i | input | 1 | Read the word twice and compare |
| half_i | input | DIV_W | Clock half period in core cycles |
| sdata_i | input | 1 | Serial data from the sensor (asynchronous) |
| sclk_o | output | 1 | Serial clock to the sensor, idle high |
| busy_o | output | 1 | Burst or guard time in progress |
| valid_o | output | 1 | One-cycle result strobe |
| word_o | output | WORD_W | Received word |
| wire_break_o | output | 1 | Data line low in idle |
| short_o | output | 1 | Data line high after the final edge |
| mismatch_o | output | 1 | Compare mode copies differ |

## Verification
The bench uses a behavioural sensor with its own retriggered timeout. It drives an all-ones word and alternating patterns at several half periods, including the minimum of 4. A reader that samples on the rising edge instead of the falling edge, or that loses time in the synchroniser, would return shifted words there. Compare-mode reads are made both clean and with a bit flipped only in the repeated copy. If the gap between bursts is too long, the sensor would refresh its value; if the wrong copy is kept or the flag is tied off, the flag or word would be wrong. Forced-low and forced-high lines check that each fault raises only its own flag and still produces a strobe. A start pulsed in the middle of the guard time must produce neither clock edges nor an extra result, and the guard must last exactly TM_CYC cycles.

// File: rtl/sync_link_pkg.sv
package sync_link_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GUARD
    } phase_e;

    typedef struct packed {
        logic brk;
        logic sht;
        logic mis;
    } report_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sync_link_sync2.sv
module sync_link_sync2 #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] ff_q;

    always_ff @(posedge clk) begin
        if (rst) ff_q <= {2{IDLE_LVL}};
        else     ff_q <= {ff_q[0], d_i};
    end

    assign q_o = ff_q[1];
endmodule

// File: rtl/sync_link_phase.sv
module sync_link_phase #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == half_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R2: a phase never runs past its programmed length
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/sync_link_guard.sv
module sync_link_guard
    import sync_link_pkg::*;
#(
    parameter int TM_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic done_o
);
    localparam int GW = cnt_bits(TM_CYC);
    logic [GW-1:0] cnt_q;

    assign done_o = en_i && (cnt_q == GW'(TM_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // R8: the guard window always starts from zero
    assert_guard_fresh_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/sync_link_reader.sv
module sync_link_reader
    import sync_link_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int DIV_W  = 10,
    parameter int TM_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_mode_i,
    input  logic [DIV_W-1:0]  half_i,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              wire_break_o,
    output logic              short_o,
    output logic              mismatch_o
);
    localparam int EDGE_W    = cnt_bits(WORD_W + 1);
    localparam int LAST_EDGE = WORD_W + 1;

    phase_e            state_q;
    logic [EDGE_W-1:0] edge_q;
    logic              pass_q;
    logic              cmp_q;
    logic [DIV_W-1:0]  half_q;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] first_q;
    logic [WORD_W-1:0] word_q;
    logic              brk_q;
    logic              sht_q;
    report_t           rep_q;
    logic              valid_q;
    logic              data_s;
    logic              tick;
    logic              guard_done;
    logic              running;

    sync_link_sync2 #(.IDLE_LVL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sdata_i),
        .q_o (data_s)
    );

    assign running = (state_q == ST_LOW) || (state_q == ST_HIGH);

    sync_link_phase #(.DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .run_i  (running),
        .half_i (half_q),
        .tick_o (tick)
    );

    sync_link_guard #(.TM_CYC(TM_CYC)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .en_i   (state_q == ST_GUARD),
        .done_o (guard_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
            pass_q  <= 1'b0;
            cmp_q   <= 1'b0;
            half_q  <= '0;
            shift_q <= '0;
            first_q <= '0;
            word_q  <= '0;
            brk_q   <= 1'b0;
            sht_q   <= 1'b0;
            rep_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cmp_q   <= cmp_mode_i;
                        half_q  <= half_i;
                        brk_q   <= !data_s;
                        sht_q   <= 1'b0;
                        edge_q  <= '0;
                        pass_q  <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        edge_q  <= edge_q + 1'b1;
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (edge_q != EDGE_W'(LAST_EDGE)) begin
                            shift_q <= {shift_q[WORD_W-2:0], data_s};
                            state_q <= ST_LOW;
                        end else if (cmp_q && !pass_q) begin
                            sht_q   <= sht_q | data_s;
                            first_q <= shift_q;
                            pass_q  <= 1'b1;
                            edge_q  <= '0;
                            state_q <= ST_LOW;
                        end else begin
                            word_q    <= cmp_q ? first_q : shift_q;
                            rep_q.brk <= brk_q;
                            rep_q.sht <= sht_q | data_s;
                            rep_q.mis <= cmp_q && (first_q != shift_q);
                            valid_q   <= 1'b1;
                            state_q   <= ST_GUARD;
                        end
                    end
                end
                ST_GUARD: begin
                    if (guard_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk_o       = (state_q != ST_LOW);
    assign busy_o       = (state_q != ST_IDLE);
    assign valid_o      = valid_q;
    assign word_o       = word_q;
    assign wire_break_o = rep_q.brk;
    assign short_o      = rep_q.sht;
    assign mismatch_o   = rep_q.mis;

    // R1: the clock rests high whenever no read is in progress
    assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sclk_o && !valid_o));

    // R7: the result strobe is a single-cycle pulse
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: a single-mode read never reports a mismatch
    assert_mismatch_single_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !cmp_q) |-> !mismatch_o);

    // R8: the clock stays high throughout the guard time
    assert_guard_clk_high_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GUARD) |-> (sclk_o && busy_o));

    // R9: a request during the guard does not restart the clock
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GUARD && !guard_done) |=> (state_q == ST_GUARD));
endmodule

// File: tb/sync_link_reader_bench.sv
`timescale 1ns/1ps
module sync_link_reader_bench;
    localparam int W     = 12;
    localparam int DW    = 10;
    localparam int TM    = 200;
    localparam int SL_TM = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          cmp_mode_i = 1'b0;
    logic [DW-1:0] half_i = 10'd5;
    logic          sdata_i;
    logic          sclk_o, busy_o, valid_o;
    logic [W-1:0]  word_o;
    logic          wire_break_o, short_o, mismatch_o;

    always #2.5 clk = ~clk;

    sync_link_reader #(.WORD_W(W), .DIV_W(DW), .TM_CYC(TM)) u_sync_link_reader (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_mode_i(cmp_mode_i),
        .half_i(half_i), .sdata_i(sdata_i), .sclk_o(sclk_o), .busy_o(busy_o),
        .valid_o(valid_o), .word_o(word_o), .wire_break_o(wire_break_o),
        .short_o(short_o), .mismatch_o(mismatch_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // behavioural sensor with retriggered timeout
    logic [W-1:0] live_val = '0;
    logic         f_brk = 1'b0, f_sht = 1'b0, f_cor = 1'b0;
    logic         sl_prev, sl_act, sl_dat;
    logic [W-1:0] sl_frz;
    int           sl_idx, sl_rep, sl_tmr;

    always @(posedge clk) begin
        if (rst) begin
            sl_prev <= 1'b1; sl_act <= 1'b0; sl_dat <= 1'b1;
            sl_frz <= '0; sl_idx <= 0; sl_rep <= 0; sl_tmr <= 0;
        end else begin
            sl_prev <= sclk_o;
            if (sclk_o != sl_prev) begin
                sl_tmr <= 0;
                if (!sclk_o && !sl_act) begin
                    sl_act <= 1'b1; sl_frz <= live_val; sl_idx <= 0; sl_rep <= 0;
                end else if (sclk_o && sl_act) begin
                    if (sl_idx == W) begin
                        sl_idx <= 0; sl_dat <= 1'b0; sl_rep <= sl_rep + 1;
                    end else begin
                        sl_dat <= sl_frz[W-1-sl_idx] ^ (f_cor && sl_rep == 1 && sl_idx == 0);
                        sl_idx <= sl_idx + 1;
                    end
                end
            end else if (sl_act) begin
                if (sl_tmr == SL_TM) begin
                    sl_act <= 1'b0; sl_dat <= 1'b1;
                end else sl_tmr <= sl_tmr + 1;
            end
        end
    end

    assign sdata_i = f_brk ? 1'b0 : (f_sht ? 1'b1 : sl_dat);

    // rising-edge counter on the serial clock
    int   rise_cnt = 0;
    logic sclk_d = 1'b1;
    always @(posedge clk) begin
        sclk_d <= sclk_o;
        if (sclk_o && !sclk_d) rise_cnt = rise_cnt + 1;
    end

    typedef struct {
        logic [W-1:0] word;
        logic         brk, sht, mis;
        int           edges;
    } exp_t;
    exp_t exp_q[$];

    // monitor / scoreboard
    logic vprev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (vprev) chk(!valid_o, "R7 valid longer than one cycle");
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected result, act valid=1 exp none");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(word_o == e.word, $sformatf("R3 word act=%h exp=%h", word_o, e.word));
                    chk(wire_break_o == e.brk, $sformatf("R4 break act=%0b exp=%0b", wire_break_o, e.brk));
                    chk(short_o == e.sht, $sformatf("R5 short act=%0b exp=%0b", short_o, e.sht));
                    chk(mismatch_o == e.mis, $sformatf("R6 mismatch act=%0b exp=%0b", mismatch_o, e.mis));
                    chk(rise_cnt == e.edges, $sformatf("R2/R6 edges act=%0d exp=%0d", rise_cnt, e.edges));
                end
            end
            vprev <= valid_o;
        end
    end

    task automatic do_read(input logic [W-1:0] val, input bit cmp, input int half,
                           input bit brk, input bit sht, input bit cor, input bit poke);
        exp_t e;
        int   n, g, e0;
        while (busy_o) @(negedge clk);
        live_val = val; f_brk = brk; f_sht = sht; f_cor = cor;
        repeat (4) @(negedge clk);
        e.word  = brk ? '0 : (sht ? '1 : val);
        e.brk   = brk;
        e.sht   = sht;
        e.mis   = cmp && cor && !brk && !sht;
        e.edges = cmp ? 2 * (W + 1) : (W + 1);
        exp_q.push_back(e);
        rise_cnt   = 0;
        half_i     = DW'(half);
        cmp_mode_i = cmp;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!sclk_o) begin n++; @(negedge clk); end
        chk(n == half, $sformatf("R2 low phase act=%0d exp=%0d", n, half));
        n = 0;
        while (sclk_o) begin n++; @(negedge clk); end
        chk(n == half, $sformatf("R2 high phase act=%0d exp=%0d", n, half));
        while (!valid_o) @(negedge clk);
        e0 = rise_cnt;
        g = 0;
        while (busy_o) begin
            start_i = (poke && g == 50);
            g++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(g == TM, $sformatf("R8 guard act=%0d exp=%0d", g, TM));
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(rise_cnt == e0, $sformatf("R9 edges after guard start act=%0d exp=%0d", rise_cnt, e0));
            chk(!busy_o, $sformatf("R9 busy act=%0b exp=0", busy_o));
        end
        f_brk = 1'b0; f_sht = 1'b0; f_cor = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk_o == 1'b1, $sformatf("R1 sclk act=%0b exp=1", sclk_o));
        chk(busy_o == 1'b0, $sformatf("R1 busy act=%0b exp=0", busy_o));
        chk(valid_o == 1'b0, $sformatf("R1 valid act=%0b exp=0", valid_o));

        do_read(12'hA5C, 1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'h123, 1'b0, 7, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'hFFF, 1'b0, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'h001, 1'b0, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'h5A5, 1'b1, 5, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'h3C7, 1'b1, 6, 1'b0, 1'b0, 1'b1, 1'b0);
        do_read(12'h6B2, 1'b0, 5, 1'b1, 1'b0, 1'b0, 1'b0);
        do_read(12'h6B2, 1'b0, 5, 1'b0, 1'b1, 1'b0, 1'b0);
        do_read(12'h2D4, 1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, $sformatf("R7 pending results act=%0d exp=0", exp_q.size()));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired, act=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule